// File: doc/BRIEF.md
# Ultraviolet-Erasable Byte Memory with Pin-Level Mode Control

This block models, at its pins, an 8K by 8 programmable read-only memory whose cells start at all ones and can only be cleared to zero by programming. Three active-low control pins (chip select, output gate and program strobe) and two level flags decide what the part does in each cycle. One flag says whether the programming supply is raised, and the other says whether the ninth address pin is raised. Depending on these inputs the part reads, verifies, programs, returns identity bytes, stays idle or is inhibited. The outputs are a data byte and an enable for the tristate bus driver. During programming, write data comes from the same bus through a separate input.

A write happens once per falling program strobe, and only while the part is in program mode. The new byte is the old byte ANDed with the bus byte. A synchronous bulk-erase input returns every word to all ones, and reset has the same effect. In a system the block stands in for the memory device. A programmer model drives the pins, and several instances can share address and data lines while only their chip selects or strobes differ.

Top module: `eprom_core`

## Requirements
- R1: After reset, every address returns 0xFF in read mode.
- R2: While `ce_n` is high, `bus_oe` is low, whatever the other pins are.
- R3: While `oe_n` and `pgm_n` are both high, `bus_oe` is low.
- R4: Read mode (`vpp_hi`=0, `a9_hi`=0, `ce_n`=0, `oe_n`=0) drives the stored byte at `addr` onto `bus_out` with `bus_oe`=1 in the same cycle.
- R5: Program mode is `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0. One write happens at the first clock edge that samples `pgm_n` low after an edge that sampled it high. Keeping `pgm_n` low writes nothing more. `bus_oe` stays low during program mode.
- R6: A write stores the old word ANDed with `bus_in`, so bits only go from 1 to 0.
- R7: Verify mode (`vpp_hi`=1, `ce_n`=0, `pgm_n`=1, `oe_n`=0) drives the stored byte with `bus_oe`=1.
- R8: A strobe pulse while `ce_n` is high, or a raised supply with `pgm_n` held high, leaves every word unchanged.
- R9: Identity mode (`a9_hi`=1, `vpp_hi`=0, `ce_n`=0, `oe_n`=0) drives 0x29 when `addr[0]`=0 and 0x02 when `addr[0]`=1. The other address bits are ignored.
- R10: `erase` high at a clock edge makes every word read 0xFF from the next cycle on. It wins over a write at the same edge.
- R11: A strobe pulse with `vpp_hi`=0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobe sampling and writes happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; restores the blank array |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply at its raised level |
| a9_hi | input | 1 | Address pin 9 at its raised level (identity request) |
| erase | input | 1 | Synchronous bulk erase to all ones |
| addr | input | 13 | Word address |
| bus_in | input | 8 | Byte present on the data bus (write data) |
| bus_out | output | 8 | Byte driven onto the data bus |
| bus_oe | output | 1 | Tristate enable for `bus_out` |

## Verification
A wrong bit in the array shows only when that address is read or verified. It then appears on `bus_out` in the same cycle as the access, because the read path has no register. A wrong strobe history has a different signature. A stuck-high history lets a held strobe write again as soon as the bus data changes. A stuck-low history loses the first write, and the following read-back of the programmed address shows it at once. A wrong cleared-word flag makes a written word read 0xFF, or makes an erase fail to restore 0xFF, and both show on the first access to that word.

// File: rtl/eprom_pkg.sv
`timescale 1ns/1ps
package eprom_pkg;
   typedef enum logic [2:0] {
      MD_IDLE    = 3'd0,
      MD_READ    = 3'd1,
      MD_QUIET   = 3'd2,
      MD_PROGRAM = 3'd3,
      MD_VERIFY  = 3'd4,
      MD_BLOCKED = 3'd5,
      MD_IDENT   = 3'd6
   } pin_mode_e;

   function automatic logic mode_drives_bus(input pin_mode_e m);
      return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
   endfunction
endpackage

// File: rtl/eprom_mode_dec.sv
`timescale 1ns/1ps
module eprom_mode_dec
   import eprom_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      pgm_n,
   input  logic      vpp_hi,
   input  logic      a9_hi,
   output pin_mode_e mode
);
   always_comb begin
      if (ce_n) begin
         mode = vpp_hi ? MD_BLOCKED : MD_IDLE;
      end else if (vpp_hi) begin
         unique case ({pgm_n, oe_n})
            2'b01:   mode = MD_PROGRAM;
            2'b10:   mode = MD_VERIFY;
            2'b11:   mode = MD_BLOCKED;
            default: mode = MD_QUIET;
         endcase
      end else if (!oe_n) begin
         mode = a9_hi ? MD_IDENT : MD_READ;
      end else begin
         mode = MD_QUIET;
      end
   end
endmodule

// File: rtl/eprom_store.sv
`timescale 1ns/1ps
module eprom_store #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DEPTH-1:0]  written;
   logic [DATA_W-1:0] cur_word;

   assign cur_word = written[addr] ? cells[addr] : {DATA_W{1'b1}};
   assign rd_data  = cur_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         written <= '0;
      end else if (erase) begin
         written <= '0;
      end else if (wr_en) begin
         written[addr] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !erase) begin
         cells[addr] <= cur_word & wr_data;
      end
   end
endmodule

// File: rtl/eprom_bus_drv.sv
`timescale 1ns/1ps
module eprom_bus_drv
   import eprom_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h29,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h02
) (
   input  pin_mode_e         mode,
   input  logic              id_sel,
   input  logic [DATA_W-1:0] cell_data,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);
   logic [DATA_W-1:0] id_byte;
   assign id_byte = id_sel ? DEV_CODE : MFR_CODE;

   always_comb begin
      bus_oe  = mode_drives_bus(mode);
      bus_out = '0;
      if (mode == MD_IDENT)
         bus_out = id_byte;
      else if (bus_oe)
         bus_out = cell_data;
   end
endmodule

// File: rtl/eprom_core.sv
`timescale 1ns/1ps
module eprom_core
   import eprom_pkg::*;
#(
   parameter int                ADDR_W     = 13,
   parameter int                DATA_W     = 8,
   parameter int                ID_SEL_BIT = 0,
   parameter logic [DATA_W-1:0] MFR_CODE   = 8'h29,
   parameter logic [DATA_W-1:0] DEV_CODE   = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pgm_n,
   input  logic              vpp_hi,
   input  logic              a9_hi,
   input  logic              erase,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("eprom_core: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("eprom_core: DATA_W must be positive");
      end
      if (ID_SEL_BIT < 0 || ID_SEL_BIT >= ADDR_W) begin : g_bad_sel
         $error("eprom_core: ID_SEL_BIT outside address");
      end
   endgenerate

   pin_mode_e         mode;
   logic              strobe_q;
   logic              wr_en;
   logic [DATA_W-1:0] cell_data;

   eprom_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .a9_hi  (a9_hi),
      .mode   (mode)
   );

   // previous strobe level; a write needs high-then-low across two edges
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b1;
      else        strobe_q <= pgm_n;
   end

   assign wr_en = (mode == MD_PROGRAM) && strobe_q;

   eprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase   (erase),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (bus_in),
      .rd_data (cell_data)
   );

   eprom_bus_drv #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_drv (
      .mode      (mode),
      .id_sel    (addr[ID_SEL_BIT]),
      .cell_data (cell_data),
      .bus_out   (bus_out),
      .bus_oe    (bus_oe)
   );
endmodule

// File: rtl/eprom_core_chk.sv
`timescale 1ns/1ps
module eprom_core_chk #(
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h29,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h02
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              pgm_n,
   input logic              vpp_hi,
   input logic              a9_hi,
   input logic              erase,
   input logic              id_sel,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_oe,
   input logic              wr_en
);
   p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> !bus_oe);

   p_gate_strobe_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n && pgm_n) |-> !bus_oe);

   p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_inhibit_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!ce_n && !pgm_n && oe_n));

   p_ident_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!vpp_hi && a9_hi && !ce_n && !oe_n) |->
         (bus_oe && bus_out == (id_sel ? DEV_CODE : MFR_CODE)));

   p_erase_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(erase) && !vpp_hi && !a9_hi && !ce_n && !oe_n) |->
         (bus_out == {DATA_W{1'b1}}));

   p_no_supply_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !vpp_hi |-> !wr_en);
endmodule

bind eprom_core eprom_core_chk #(
   .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ce_n    (ce_n),
   .oe_n    (oe_n),
   .pgm_n   (pgm_n),
   .vpp_hi  (vpp_hi),
   .a9_hi   (a9_hi),
   .erase   (erase),
   .id_sel  (addr[ID_SEL_BIT]),
   .bus_out (bus_out),
   .bus_oe  (bus_oe),
   .wr_en   (wr_en)
);

// File: tb/sim_eprom_core.sv
`timescale 1ns/1ps
module sim_eprom_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
   logic        vpp_hi = 1'b0, a9_hi = 1'b0, erase = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  bus_in = '0;
   logic [7:0]  bus_out;
   logic        bus_oe;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   eprom_core u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
      .vpp_hi(vpp_hi), .a9_hi(a9_hi), .erase(erase), .addr(addr),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
   );

   task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic idle_pins();
      ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1;
      vpp_hi = 1'b0; a9_hi = 1'b0; erase = 1'b0;
   endtask

   // read mode access; bus_oe and bus_out sampled 1 ns after the change
   task automatic read_at(input logic [12:0] a, output logic [8:0] res);
      @(negedge clk);
      idle_pins();
      ce_n = 1'b0; oe_n = 1'b0; addr = a;
      #1 res = {bus_oe, bus_out};
   endtask

   task automatic strobe(input logic vpp, input logic cen, input logic [12:0] a,
                         input logic [7:0] d, input int low_cycles);
      @(negedge clk);
      idle_pins();
      vpp_hi = vpp; ce_n = cen; oe_n = 1'b1; addr = a; bus_in = d;
      @(negedge clk);
      pgm_n = 1'b0;
      repeat (low_cycles) @(negedge clk);
      pgm_n = 1'b1;
      @(negedge clk);
      idle_pins();
   endtask

   task automatic t_reset();
      logic [8:0] r;
      read_at(13'h0000, r); check("R1 addr 0000", r, 9'h1FF);
      read_at(13'h1FFF, r); check("R1 addr 1fff", r, 9'h1FF);
      read_at(13'h0A55, r); check("R4 read blank", r, 9'h1FF);
   endtask

   task automatic t_program();
      logic [8:0] r;
      strobe(1'b1, 1'b0, 13'h0123, 8'hF0, 1);
      read_at(13'h0123, r); check("R5 first write", r, 9'h1F0);
      strobe(1'b1, 1'b0, 13'h0123, 8'h3C, 1);
      read_at(13'h0123, r); check("R6 and of old and new", r, 9'h130);
      strobe(1'b1, 1'b0, 13'h1FFF, 8'h00, 2);
      read_at(13'h1FFF, r); check("R4 read top word", r, 9'h100);
      read_at(13'h0124, r); check("R4 neighbour untouched", r, 9'h1FF);
   endtask

   task automatic t_hold_low();
      logic [8:0] r;
      @(negedge clk);
      idle_pins();
      vpp_hi = 1'b1; ce_n = 1'b0; addr = 13'h0040; bus_in = 8'hF0;
      @(negedge clk);
      pgm_n = 1'b0;
      #1 check("R5 bus off in program", {8'h00, bus_oe}, 9'h000);
      @(negedge clk);
      bus_in = 8'h0F;
      repeat (3) @(negedge clk);
      idle_pins();
      read_at(13'h0040, r); check("R5 one write per pulse", r, 9'h1F0);
   endtask

   task automatic t_verify();
      logic [8:0] r;
      @(negedge clk);
      idle_pins();
      vpp_hi = 1'b1; ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; addr = 13'h0123;
      #1 r = {bus_oe, bus_out};
      check("R7 verify drives byte", r, 9'h130);
   endtask

   task automatic t_inhibit();
      logic [8:0] r;
      strobe(1'b1, 1'b1, 13'h0200, 8'h00, 1);
      read_at(13'h0200, r); check("R8 ce high pulse", r, 9'h1FF);
      @(negedge clk);
      idle_pins();
      vpp_hi = 1'b1; ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b1; addr = 13'h0201; bus_in = 8'h00;
      #1 check("R3 gate and strobe high", {8'h00, bus_oe}, 9'h000);
      repeat (3) @(negedge clk);
      idle_pins();
      read_at(13'h0201, r); check("R8 strobe held high", r, 9'h1FF);
   endtask

   task automatic t_no_supply();
      logic [8:0] r;
      strobe(1'b0, 1'b0, 13'h0300, 8'h00, 1);
      read_at(13'h0300, r); check("R11 no supply no write", r, 9'h1FF);
   endtask

   task automatic t_standby();
      @(negedge clk);
      idle_pins();
      ce_n = 1'b1; oe_n = 1'b0; pgm_n = 1'b0; addr = 13'h0123;
      #1 check("R2 standby bus off", {8'h00, bus_oe}, 9'h000);
      vpp_hi = 1'b1; oe_n = 1'b0; pgm_n = 1'b1;
      #1 check("R2 ce high with supply", {8'h00, bus_oe}, 9'h000);
   endtask

   task automatic t_identity();
      @(negedge clk);
      idle_pins();
      ce_n = 1'b0; oe_n = 1'b0; a9_hi = 1'b1; addr = 13'h0000;
      #1 check("R9 maker code", {bus_oe, bus_out}, 9'h129);
      addr = 13'h0001;
      #1 check("R9 device code", {bus_oe, bus_out}, 9'h102);
      addr = 13'h1FFE;
      #1 check("R9 upper bits ignored", {bus_oe, bus_out}, 9'h129);
   endtask

   task automatic t_erase();
      logic [8:0] r;
      @(negedge clk);
      idle_pins();
      erase = 1'b1;
      @(negedge clk);
      erase = 1'b0;
      read_at(13'h0123, r); check("R10 erased word", r, 9'h1FF);
      read_at(13'h1FFF, r); check("R10 erased top word", r, 9'h1FF);
      // erase and a write at the same edge: erase wins
      @(negedge clk);
      idle_pins();
      vpp_hi = 1'b1; ce_n = 1'b0; addr = 13'h0500; bus_in = 8'h00;
      @(negedge clk);
      pgm_n = 1'b0; erase = 1'b1;
      @(negedge clk);
      idle_pins();
      read_at(13'h0500, r); check("R10 erase beats write", r, 9'h1FF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_hold_low();
      t_verify();
      t_inhibit();
      t_no_supply();
      t_standby();
      t_identity();
      t_erase();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired got=running exp=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule